// File: doc/BRIEF.md
# Register-Machine Instruction Decoder with Wide-Constant Merge

This block sits at the front of an instruction pipeline for a 64-bit register machine. It takes a stream of 64-bit instruction words and turns each instruction into a decoded bundle. The bundle holds the instruction class, the operation code, the operand-source selector, the destination and source register numbers, a sign-extended offset, a 64-bit immediate and two flags: one marks a wide instruction and one marks an illegal one.

Most instructions fit in one word. The wide constant-load form spans two words. The first word carries the low half of the constant. The second word is a pseudo-word whose only payload is the high half; every other field of it must be zero. The decoder holds the first word until the pseudo-word arrives and then emits a single bundle. A wide instruction that is cut short by the end of the stream is flagged illegal.

Both sides use a valid/ready handshake. The decoder keeps one output register and accepts input whenever that register is empty or is being drained in the same cycle.

Top module: `vmi_decoder`

## Requirements
- R1: Field split of a word: opcode in bits [7:0], destination register in bits [11:8], source register in bits [15:12], signed offset in bits [31:16], signed immediate in bits [63:32]. The offset is sign-extended to OFF_OUT_W bits. For a one-word instruction, the immediate is sign-extended to 64 bits.
- R2: The class is opcode bits [2:0]. Classes 4 to 7 are the arithmetic and branch classes; for them the flag out_arith_branch is set, the operation code is opcode bits [7:4] and the source selector is opcode bit 3 (0 means the immediate is the operand, 1 means the source register is). For classes 0 to 3, the operation code is zero and the selector is zero.
- R3: A destination register number above 10 makes the instruction illegal. For a one-word instruction, a source register number above 10 also makes it illegal.
- R4: A word with opcode 0x18 that is not marked last starts a wide instruction. The next accepted word completes it. Exactly one bundle results, with out_wide set and the immediate equal to (second word bits [63:32] << 32) | first word bits [63:32]. The register and offset fields come from the first word.
- R5: In a wide instruction, the source register field is not range-checked.
- R6: If bits [31:0] of the pseudo-word are not all zero, the wide bundle is still emitted, with out_illegal set.
- R7: If a word with opcode 0x18 is marked last, it is emitted at once with out_wide and out_illegal set. Its immediate is the zero-extended first-word immediate. The next word is then decoded as a first word.
- R8: While out_valid is high and out_ready is low, the bundle holds steady and in_ready is low. Otherwise in_ready is high. A bundle appears on the cycle after the word that completes it is accepted.
- R9: Synchronous reset clears the output register and any half-assembled wide instruction. After reset, out_valid is 0, in_ready is 1, and the next word is decoded as a first word.
- R10: in_last on a word that does not start a wide instruction has no effect on its decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 64 | Instruction word |
| in_last | input | 1 | Word is the final one of the stream |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_class | output | 3 | Instruction class |
| out_code | output | 4 | Operation code (arithmetic and branch classes only) |
| out_src_sel | output | 1 | 1 = register operand, 0 = immediate operand |
| out_arith_branch | output | 1 | Class is arithmetic or branch |
| out_dst | output | 4 | Destination register number |
| out_src | output | 4 | Source register field |
| out_offset | output | OFF_OUT_W | Sign-extended offset |
| out_imm | output | 64 | Sign-extended or assembled immediate |
| out_wide | output | 1 | Bundle came from the two-word form |
| out_illegal | output | 1 | Range, reserved-field or truncation fault |

## Verification
The bench builds the decoder with its default parameters: register limit 10, offset widened to the full 64 bits, wide opcode 0x18, and pseudo-word checking enabled. With these values the register-number boundary between 10 and 11 can be probed on both register fields. Negative offsets and immediates show the full sign extension. Pseudo-words with stray bits in the opcode or offset fields reach the reserved-field check. A bursty out_ready pattern stalls the output register while a wide instruction is half assembled, and a reset applied between the two halves of a wide instruction shows that the pending word is discarded.

// File: rtl/vmi_pkg.sv
package vmi_pkg;
   localparam int WORD_W  = 64;
   localparam int OPC_W   = 8;
   localparam int REGN_W  = 4;
   localparam int RAWOFF_W = 16;
   localparam int HALF_W  = 32;
   localparam int CLS_W   = 3;
   localparam int CODE_W  = 4;

   typedef enum logic [CLS_W-1:0] {
      CLS_LOAD_IMM  = 3'd0,
      CLS_LOAD_REG  = 3'd1,
      CLS_STORE_IMM = 3'd2,
      CLS_STORE_REG = 3'd3,
      CLS_ARITH32   = 3'd4,
      CLS_BRANCH    = 3'd5,
      CLS_BRANCH32  = 3'd6,
      CLS_ARITH64   = 3'd7
   } insn_class_e;

   // packed MSB first so a word casts straight onto the fields
   typedef struct packed {
      logic [HALF_W-1:0]   imm;
      logic [RAWOFF_W-1:0] off;
      logic [REGN_W-1:0]   srcn;
      logic [REGN_W-1:0]   dstn;
      logic [OPC_W-1:0]    opc;
   } raw_fields_t;
endpackage

// File: rtl/vmi_field_split.sv
module vmi_field_split
   import vmi_pkg::*;
#(
   parameter int OFF_OUT_W = 64
) (
   input  logic [WORD_W-1:0]    word,
   output raw_fields_t          fld,
   output insn_class_e          cls,
   output logic [CODE_W-1:0]    code,
   output logic                 src_sel,
   output logic                 arith_branch,
   output logic [OFF_OUT_W-1:0] off_x,
   output logic [WORD_W-1:0]    imm_x
);
   localparam int OFF_PAD = OFF_OUT_W - RAWOFF_W;
   localparam int IMM_PAD = WORD_W - HALF_W;

   assign fld = raw_fields_t'(word);

   always_comb begin
      cls          = insn_class_e'(fld.opc[CLS_W-1:0]);
      arith_branch = fld.opc[CLS_W-1];
      code         = arith_branch ? fld.opc[OPC_W-1 -: CODE_W] : '0;
      src_sel      = arith_branch ? fld.opc[CLS_W] : 1'b0;
   end

   generate
      if (OFF_PAD > 0) begin : g_off_ext
         assign off_x = {{OFF_PAD{fld.off[RAWOFF_W-1]}}, fld.off};
      end else begin : g_off_raw
         assign off_x = fld.off;
      end
   endgenerate

   assign imm_x = {{IMM_PAD{fld.imm[HALF_W-1]}}, fld.imm};
endmodule

// File: rtl/vmi_reg_check.sv
module vmi_reg_check
   import vmi_pkg::*;
#(
   parameter int REG_LIMIT = 10,
   parameter int NUM_FLD   = 2
) (
   input  logic [NUM_FLD-1:0][REGN_W-1:0] regs,
   input  logic [NUM_FLD-1:0]             check_en,
   output logic                           bad
);
   localparam logic [REGN_W-1:0] LIM = REG_LIMIT[REGN_W-1:0];
   localparam int MAX_REG = (1 << REGN_W) - 1;

   generate
      if (REG_LIMIT >= MAX_REG) begin : g_no_limit
         assign bad = 1'b0;
      end else begin : g_limit
         logic [NUM_FLD-1:0] over;
         for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
            assign over[i] = check_en[i] && (regs[i] > LIM);
         end
         assign bad = |over;
      end
   endgenerate
endmodule

// File: rtl/vmi_wide_merge.sv
module vmi_wide_merge
   import vmi_pkg::*;
#(
   parameter logic [OPC_W-1:0] WIDE_OPCODE  = 8'h18,
   parameter bit               CHECK_PSEUDO = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_last,
   output logic              pend,
   output logic [WORD_W-1:0] base_word,
   output logic [HALF_W-1:0] hi_imm,
   output logic              emit,
   output logic              emit_wide,
   output logic              emit_trunc,
   output logic              pseudo_bad
);
   logic [WORD_W-1:0] held_word;
   logic              starts_wide;

   assign starts_wide = (in_word[OPC_W-1:0] == WIDE_OPCODE);

   always_comb begin
      if (pend) begin
         base_word  = held_word;
         hi_imm     = in_word[WORD_W-1 -: HALF_W];
         emit       = fire;
         emit_wide  = 1'b1;
         emit_trunc = 1'b0;
      end else begin
         base_word  = in_word;
         hi_imm     = '0;
         emit       = fire && !(starts_wide && !in_last);
         emit_wide  = starts_wide;
         emit_trunc = starts_wide && in_last;
      end
   end

   generate
      if (CHECK_PSEUDO) begin : g_pseudo_chk
         assign pseudo_bad = pend && (|in_word[HALF_W-1:0]);
      end else begin : g_pseudo_skip
         assign pseudo_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pend      <= 1'b0;
         held_word <= '0;
      end else if (fire) begin
         if (pend) begin
            pend <= 1'b0;
         end else if (starts_wide && !in_last) begin
            pend      <= 1'b1;
            held_word <= in_word;
         end
      end
   end
endmodule

// File: rtl/vmi_decoder.sv
module vmi_decoder
   import vmi_pkg::*;
#(
   parameter int               OFF_OUT_W    = 64,
   parameter int               REG_LIMIT    = 10,
   parameter logic [7:0]       WIDE_OPCODE  = 8'h18,
   parameter bit               CHECK_PSEUDO = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [63:0]          in_word,
   input  logic                 in_last,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [2:0]           out_class,
   output logic [3:0]           out_code,
   output logic                 out_src_sel,
   output logic                 out_arith_branch,
   output logic [3:0]           out_dst,
   output logic [3:0]           out_src,
   output logic [OFF_OUT_W-1:0] out_offset,
   output logic [63:0]          out_imm,
   output logic                 out_wide,
   output logic                 out_illegal
);
   generate
      if (OFF_OUT_W < RAWOFF_W) begin : g_bad_off_w
         $error("OFF_OUT_W must be at least the raw offset width");
      end
      if (REG_LIMIT < 0 || REG_LIMIT > 15) begin : g_bad_limit
         $error("REG_LIMIT must fit a register field");
      end
   endgenerate

   logic              fire;
   logic              pend;
   logic [WORD_W-1:0] base_word;
   logic [HALF_W-1:0] hi_imm;
   logic              emit, emit_wide, emit_trunc, pseudo_bad;

   raw_fields_t           fld;
   insn_class_e           cls;
   logic [CODE_W-1:0]     code;
   logic                  src_sel, arith_branch;
   logic [OFF_OUT_W-1:0]  off_x;
   logic [WORD_W-1:0]     imm_x;
   logic                  reg_bad;
   logic [WORD_W-1:0]     imm_next;
   logic                  illegal_next;

   assign in_ready = !out_valid || out_ready;
   assign fire     = in_valid && in_ready;

   vmi_wide_merge #(
      .WIDE_OPCODE  (WIDE_OPCODE),
      .CHECK_PSEUDO (CHECK_PSEUDO)
   ) u_merge (
      .clk        (clk),
      .rst        (rst),
      .fire       (fire),
      .in_word    (in_word),
      .in_last    (in_last),
      .pend       (pend),
      .base_word  (base_word),
      .hi_imm     (hi_imm),
      .emit       (emit),
      .emit_wide  (emit_wide),
      .emit_trunc (emit_trunc),
      .pseudo_bad (pseudo_bad)
   );

   vmi_field_split #(
      .OFF_OUT_W (OFF_OUT_W)
   ) u_split (
      .word         (base_word),
      .fld          (fld),
      .cls          (cls),
      .code         (code),
      .src_sel      (src_sel),
      .arith_branch (arith_branch),
      .off_x        (off_x),
      .imm_x        (imm_x)
   );

   vmi_reg_check #(
      .REG_LIMIT (REG_LIMIT),
      .NUM_FLD   (2)
   ) u_regchk (
      .regs     ({fld.srcn, fld.dstn}),
      .check_en ({!emit_wide, 1'b1}),
      .bad      (reg_bad)
   );

   always_comb begin
      imm_next     = emit_wide ? {hi_imm, fld.imm} : imm_x;
      illegal_next = reg_bad || pseudo_bad || emit_trunc;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid        <= 1'b0;
         out_class        <= '0;
         out_code         <= '0;
         out_src_sel      <= 1'b0;
         out_arith_branch <= 1'b0;
         out_dst          <= '0;
         out_src          <= '0;
         out_offset       <= '0;
         out_imm          <= '0;
         out_wide         <= 1'b0;
         out_illegal      <= 1'b0;
      end else if (emit) begin
         out_valid        <= 1'b1;
         out_class        <= cls;
         out_code         <= code;
         out_src_sel      <= src_sel;
         out_arith_branch <= arith_branch;
         out_dst          <= fld.dstn;
         out_src          <= fld.srcn;
         out_offset       <= off_x;
         out_imm          <= imm_next;
         out_wide         <= emit_wide;
         out_illegal      <= illegal_next;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/vmi_decoder_chk.sv
module vmi_decoder_chk #(
   parameter int         OFF_OUT_W   = 64,
   parameter int         REG_LIMIT   = 10,
   parameter logic [7:0] WIDE_OPCODE = 8'h18
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic [63:0]          in_word,
   input logic                 in_last,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [2:0]           out_class,
   input logic [3:0]           out_code,
   input logic                 out_src_sel,
   input logic                 out_arith_branch,
   input logic [3:0]           out_dst,
   input logic [3:0]           out_src,
   input logic [OFF_OUT_W-1:0] out_offset,
   input logic [63:0]          out_imm,
   input logic                 out_wide,
   input logic                 out_illegal,
   input logic                 pend
);
   localparam logic [3:0] LIM = REG_LIMIT[3:0];

   a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_imm) && $stable(out_offset)
         && $stable(out_dst) && $stable(out_src) && $stable(out_class) && $stable(out_code)
         && $stable(out_src_sel) && $stable(out_wide) && $stable(out_illegal));

   a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   a_r4_open_pending: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && !pend && in_word[7:0] == WIDE_OPCODE && !in_last |=> pend);

   a_r4_merge_emits: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && pend |=> out_valid && out_wide && !pend);

   a_r7_truncated: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && !pend && in_word[7:0] == WIDE_OPCODE && in_last
      |=> out_valid && out_wide && out_illegal && !pend);

   a_r3_reg_range: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_wide && (out_dst > LIM || out_src > LIM) |-> out_illegal);

   a_r2_nonarith_zero: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_arith_branch |-> out_code == 4'd0 && !out_src_sel && !out_class[2]);
endmodule

bind vmi_decoder vmi_decoder_chk #(
   .OFF_OUT_W   (OFF_OUT_W),
   .REG_LIMIT   (REG_LIMIT),
   .WIDE_OPCODE (WIDE_OPCODE)
) u_chk (
   .clk              (clk),
   .rst              (rst),
   .in_valid         (in_valid),
   .in_ready         (in_ready),
   .in_word          (in_word),
   .in_last          (in_last),
   .out_valid        (out_valid),
   .out_ready        (out_ready),
   .out_class        (out_class),
   .out_code         (out_code),
   .out_src_sel      (out_src_sel),
   .out_arith_branch (out_arith_branch),
   .out_dst          (out_dst),
   .out_src          (out_src),
   .out_offset       (out_offset),
   .out_imm          (out_imm),
   .out_wide         (out_wide),
   .out_illegal      (out_illegal),
   .pend             (pend)
);

// File: tb/test_vmi_decoder.sv
`timescale 1ns/1ps
module test_vmi_decoder;
   typedef struct packed {
      logic [2:0]  cls;
      logic [3:0]  code;
      logic        sel;
      logic        ab;
      logic [3:0]  dst;
      logic [3:0]  src;
      logic [63:0] off;
      logic [63:0] imm;
      logic        wide;
      logic        ill;
   } bundle_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_word = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [2:0]  out_class;
   logic [3:0]  out_code;
   logic        out_src_sel, out_arith_branch;
   logic [3:0]  out_dst, out_src;
   logic [63:0] out_offset, out_imm;
   logic        out_wide, out_illegal;

   always #2 clk = ~clk;

   vmi_decoder i_vmi_decoder (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_class(out_class), .out_code(out_code),
      .out_src_sel(out_src_sel), .out_arith_branch(out_arith_branch),
      .out_dst(out_dst), .out_src(out_src), .out_offset(out_offset),
      .out_imm(out_imm), .out_wide(out_wide), .out_illegal(out_illegal)
   );

   int total = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 0;

   logic [64:0] stim[$];
   bundle_t     expq[$];
   string       tagq[$];
   logic        mpend = 1'b0;
   logic [63:0] mfirst = '0;

   task automatic check(input bit ok, input string req, input string what);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s", req, what);
      end
   endtask

   function automatic logic [63:0] mk(input int opc, input int dst, input int src,
                                     input int off, input int imm);
      logic [63:0] w;
      w[7:0]   = opc[7:0];
      w[11:8]  = dst[3:0];
      w[15:12] = src[3:0];
      w[31:16] = off[15:0];
      w[63:32] = imm[31:0];
      return w;
   endfunction

   function automatic bundle_t one_word(input logic [63:0] w);
      bundle_t e;
      int      op;
      op     = int'(w[7:0]);
      e.cls  = 3'(op % 8);
      e.ab   = (op % 8) >= 4;
      e.code = e.ab ? 4'(op / 16) : 4'd0;
      e.sel  = e.ab ? ((op / 8) % 2 == 1) : 1'b0;
      e.dst  = w[11:8];
      e.src  = w[15:12];
      e.off  = 64'($signed(w[31:16]));
      e.imm  = 64'($signed(w[63:32]));
      e.wide = 1'b0;
      e.ill  = (int'(w[11:8]) > 10) || (int'(w[15:12]) > 10);
      return e;
   endfunction

   task automatic model(input logic [64:0] s);
      logic [63:0] w;
      logic        last;
      bundle_t     e;
      {last, w} = s;
      if (mpend) begin
         e      = one_word(mfirst);
         e.wide = 1'b1;
         e.imm  = {w[63:32], mfirst[63:32]};
         e.ill  = (int'(mfirst[11:8]) > 10) || (w[31:0] != 32'd0);
         mpend  = 1'b0;
         expq.push_back(e);
         tagq.push_back(e.ill ? "R6 R3" : "R4 R5");
      end else if (w[7:0] == 8'h18 && !last) begin
         mpend  = 1'b1;
         mfirst = w;
      end else if (w[7:0] == 8'h18) begin
         e      = one_word(w);
         e.wide = 1'b1;
         e.imm  = {32'd0, w[63:32]};
         e.ill  = 1'b1;
         expq.push_back(e);
         tagq.push_back("R7");
      end else begin
         e = one_word(w);
         expq.push_back(e);
         tagq.push_back(e.ill ? "R3" : (last ? "R10 R1 R2" : "R1 R2"));
      end
   endtask

   function automatic bundle_t actual();
      bundle_t a;
      a = '{out_class, out_code, out_src_sel, out_arith_branch, out_dst, out_src,
            out_offset, out_imm, out_wide, out_illegal};
      return a;
   endfunction

   function automatic bit ready_pattern(input int c);
      return (c % 5 != 2) && !(c >= 30 && c < 38);
   endfunction

   bundle_t prev_b;
   bit      prev_stall = 0;

   task automatic run_list();
      int idx = 0;
      int guard = 0;
      while ((idx < stim.size() || expq.size() != 0) && guard < 3000) begin
         @(negedge clk);
         out_ready = ready_pattern(cyc);
         if (idx < stim.size()) begin
            in_valid = 1'b1;
            {in_last, in_word} = stim[idx];
         end else begin
            in_valid = 1'b0;
         end
         #1;
         if (prev_stall)
            check(out_valid && actual() == prev_b, "R8",
                  $sformatf("stalled bundle moved: actual %h expected %h", actual(), prev_b));
         prev_stall = out_valid && !out_ready;
         prev_b     = actual();
         if (prev_stall)
            check(!in_ready, "R8", $sformatf("in_ready actual %b expected 0", in_ready));
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R4", "extra bundle: actual 1 expected 0");
            end else begin
               bundle_t e;
               string   t;
               e = expq.pop_front();
               t = tagq.pop_front();
               check(actual() == e, t,
                     $sformatf("bundle actual %h expected %h", actual(), e));
            end
         end
         if (in_valid && in_ready) begin
            model(stim[idx]);
            idx++;
         end
         cyc++;
         guard++;
      end
      @(negedge clk);
      in_valid  = 1'b0;
      in_last   = 1'b0;
      out_ready = 1'b1;
      stim.delete();
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL R8 watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R9: state right after reset
      check(out_valid == 1'b0, "R9", $sformatf("out_valid actual %b expected 0", out_valid));
      check(in_ready == 1'b1, "R9", $sformatf("in_ready actual %b expected 1", in_ready));

      // R1 R2: register-operand and immediate-operand arithmetic, branches, stores
      stim.push_back({1'b0, mk(8'h0f, 1, 2, 0, 5)});
      stim.push_back({1'b0, mk(8'h04, 3, 0, 0, 32'hFFFFFFF0)});
      stim.push_back({1'b0, mk(8'h05, 0, 0, 16'hFFFE, 0)});
      stim.push_back({1'b0, mk(8'h7b, 10, 10, 16'h0008, 0)});
      stim.push_back({1'b0, mk(8'hdd, 4, 7, 16'h8000, 32'h80000000)});
      stim.push_back({1'b0, mk(8'h61, 6, 9, 16'h7FFF, 0)});
      // R3: register range on both fields
      stim.push_back({1'b0, mk(8'hbf, 11, 0, 0, 0)});
      stim.push_back({1'b0, mk(8'h2f, 0, 15, 0, 0)});
      // R4 R5: legal wide, then wide with source field out of range
      stim.push_back({1'b0, mk(8'h18, 3, 1, 0, 32'h89ABCDEF)});
      stim.push_back({1'b0, mk(0, 0, 0, 0, 32'h01234567)});
      stim.push_back({1'b0, mk(8'h18, 10, 15, 0, 32'hFFFFFFFF)});
      stim.push_back({1'b1, mk(0, 0, 0, 0, 32'h80000000)});
      // R3 on a wide destination
      stim.push_back({1'b0, mk(8'h18, 12, 0, 0, 1)});
      stim.push_back({1'b0, mk(0, 0, 0, 0, 2)});
      // R6: pseudo-word with stray opcode, then stray offset
      stim.push_back({1'b0, mk(8'h18, 2, 0, 0, 3)});
      stim.push_back({1'b0, mk(8'h07, 0, 0, 0, 4)});
      stim.push_back({1'b0, mk(8'h18, 2, 0, 0, 5)});
      stim.push_back({1'b0, mk(0, 0, 0, 16'h0001, 6)});
      // R7: wide start at end of stream, followed by a normal word
      stim.push_back({1'b1, mk(8'h18, 5, 0, 0, 32'hC0000001)});
      stim.push_back({1'b0, mk(8'h07, 5, 0, 0, 9)});
      // R10: last flag on one-word instructions
      stim.push_back({1'b1, mk(8'h95, 0, 0, 0, 0)});
      stim.push_back({1'b1, mk(8'h1c, 8, 3, 16'hFFFF, 32'h7FFFFFFF)});
      // burst behind a stall window
      for (int i = 0; i < 12; i++)
         stim.push_back({1'b0, mk((i % 2 == 0) ? 8'h18 : 8'h00, i % 11, 0, 0, i * 1000)});
      run_list();
      check(expq.size() == 0 && !mpend, "R4",
            $sformatf("leftover bundles actual %0d expected 0", expq.size()));

      // R9: reset between the two halves of a wide instruction
      stim.push_back({1'b0, mk(8'h18, 1, 0, 0, 32'h11111111)});
      run_list();
      rst = 1'b1;
      mpend = 1'b0;
      prev_stall = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      check(out_valid == 1'b0, "R9", $sformatf("out_valid actual %b expected 0", out_valid));
      stim.push_back({1'b0, mk(8'h07, 2, 0, 0, 32'h1234)});
      stim.push_back({1'b0, mk(8'h00, 0, 0, 0, 0)});
      run_list();
      check(expq.size() == 0, "R9",
            $sformatf("leftover bundles actual %0d expected 0", expq.size()));

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule